// File: doc/BRIEF.md
# Serial Transmitter with Clear-to-Send Gating

This block turns bytes into asynchronous serial frames. Software, or any producer on the chip, pushes bytes into an eight-entry queue. A shift engine takes them out one at a time and sends each one on a single output line. Every bit lasts sixteen pulses of an oversampling tick supplied from outside. The character size, the parity and the stop length are set by static configuration inputs, which are captured when each frame starts.

Sending can be paused in two ways. The first is a transmit-disable input. The second is an active-low clear-to-send input, which is honoured when hardware flow control is switched on. Either way, only the start of a frame is held back, so a frame already on the line always finishes. A break input forces the line low. The queue can be emptied by a clear request, which takes effect only when its enable is also high. Two status outputs drive the rest of the system: an all-sent flag, and an interrupt request that fires at a selectable queue level.

Top module: `uart_tx_cts`

## Requirements
- R1: The queue holds up to 8 bytes. `fifo_full` is high when 8 bytes are held. A write while the queue is full is dropped and never sent.
- R2: The line idles high, and `txd` is 1 after reset. A frame is one low start bit, then the data bits LSB first, then the optional parity bit, then the stop bits, which are high. Each bit lasts 16 `tick` pulses. Bytes are sent in the order they were written.
- R3: `cfg_mode` = 2'b01 sends 7 data bits, and bit 7 of the byte is not sent. Any other value sends 8 data bits.
- R4: When `cfg_par_en` = 1, one parity bit follows the last data bit. With `cfg_par_even` = 1 it makes the count of ones in data plus parity even. With `cfg_par_even` = 0 it makes that count odd.
- R5: `cfg_stop2` = 0 sends one stop bit and `cfg_stop2` = 1 sends two.
- R6: From the cycle after `cfg_brk` goes high until the cycle after it falls, `txd` is held at 0.
- R7: While `cfg_tx_dis` = 1, no new frame starts. A frame already started completes.
- R8: With `cfg_cts_flow` = 1, a frame starts only while `cts_n` = 0. `cts_n` is looked at only between frames, so raising it mid-frame does not cut that frame short. With `cfg_cts_flow` = 0, `cts_n` is ignored.
- R9: `all_sent` is 1 only when the queue is empty and no frame is in progress, up to the end of the last stop bit. It is 1 after reset.
- R10: When `fifo_clr` = 1 and `fifo_clr_en` = 1, the queue is emptied, and a write in the same cycle is dropped. `fifo_clr` alone has no effect.
- R11: `tx_irq` depends on `irq_lvl`. With 2'b00 it is high when the queue is empty. With 2'b01 it is high when at most 4 bytes are held. With 2'b10 or 2'b11 it is high when at most 7 bytes are held. It is high after reset.
- R12: A write that lands in the same cycle as a frame start both take effect. The queue occupancy is then unchanged, and both bytes are sent in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Oversampling tick, 16 per bit |
| wr_en | input | 1 | Write a byte into the queue |
| wr_data | input | 8 | Byte to write |
| fifo_clr | input | 1 | Queue clear request |
| fifo_clr_en | input | 1 | Qualifier for the clear request |
| cfg_mode | input | 2 | Character size: 01 gives 7 bits, otherwise 8 |
| cfg_stop2 | input | 1 | Two stop bits when 1 |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_even | input | 1 | Even parity when 1, odd when 0 |
| cfg_brk | input | 1 | Force the line low |
| cfg_tx_dis | input | 1 | Hold off new frames |
| cfg_cts_flow | input | 1 | Gate frame starts on clear-to-send |
| cts_n | input | 1 | Clear-to-send, active low |
| irq_lvl | input | 2 | Interrupt level select |
| txd | output | 1 | Serial output |
| all_sent | output | 1 | Queue empty and shifter idle |
| tx_irq | output | 1 | Queue-level interrupt request |
| fifo_full | output | 1 | Queue holds 8 bytes |

## Verification
Two events can land in the same clock edge: a producer write into the queue, and the pop made when a frame starts. The bench provokes this by holding one byte behind the transmit-disable input. It then waits for a cycle in which the tick is due. In that cycle it releases transmission and writes a second byte together, and closes the gate again one cycle later. The result is judged at the ports. The interrupt level must show exactly one byte still held, only the first frame may leave while the gate is closed, and both bytes must arrive intact and in order once the gate reopens.

// File: rtl/uart_tx_cts.sv
module uart_tx_cts #(
  parameter int DEPTH = 8,
  parameter int OSR   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       fifo_clr,
  input  logic       fifo_clr_en,
  input  logic [1:0] cfg_mode,
  input  logic       cfg_stop2,
  input  logic       cfg_par_en,
  input  logic       cfg_par_even,
  input  logic       cfg_brk,
  input  logic       cfg_tx_dis,
  input  logic       cfg_cts_flow,
  input  logic       cts_n,
  input  logic [1:0] irq_lvl,
  output logic       txd,
  output logic       all_sent,
  output logic       tx_irq,
  output logic       fifo_full
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int TW = (OSR > 1) ? $clog2(OSR) : 1;
  localparam int FW = 12;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count;
  logic          busy;
  logic [FW-1:0] sh;
  logic [3:0]    bits_left;
  logic [TW-1:0] tcnt;

  logic          clr, push, start, fifo_empty;
  logic [7:0]    head;
  logic          len7, par_bit;
  logic [FW-2:0] tail;
  logic [FW-1:0] frame;
  logic [3:0]    nbits;

  assign clr        = fifo_clr & fifo_clr_en;
  assign fifo_empty = (count == '0);
  assign fifo_full  = (count == CW'(DEPTH));
  assign push       = wr_en & ~fifo_full & ~clr;
  assign start      = tick & ~busy & ~fifo_empty & ~cfg_tx_dis & ~clr &
                      (~cfg_cts_flow | ~cts_n);
  assign all_sent   = fifo_empty & ~busy;

  always_comb begin
    case (irq_lvl)
      2'b00:   tx_irq = fifo_empty;
      2'b01:   tx_irq = (count <= CW'(DEPTH / 2));
      default: tx_irq = (count < CW'(DEPTH));
    endcase
  end

  always_comb begin
    head    = mem[rd_ptr];
    len7    = (cfg_mode == 2'b01);
    par_bit = (len7 ? ^head[6:0] : ^head) ^ ~cfg_par_even;
    tail    = '1;
    tail[6:0] = head[6:0];
    if (!len7) tail[7] = head[7];
    if (cfg_par_en) begin
      if (len7) tail[7] = par_bit;
      else      tail[8] = par_bit;
    end
    frame = {tail, 1'b0};
    nbits = 4'd10 - {3'b0, len7} + {3'b0, cfg_par_en} + {3'b0, cfg_stop2};
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else if (clr) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push)  wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (start) rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      if (push && !start)      count <= count + 1'b1;
      else if (start && !push) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      sh        <= '1;
      bits_left <= '0;
      tcnt      <= '0;
    end else if (start) begin
      busy      <= 1'b1;
      sh        <= frame;
      bits_left <= nbits;
      tcnt      <= '0;
    end else if (busy && tick) begin
      if (tcnt == TW'(OSR - 1)) begin
        tcnt      <= '0;
        sh        <= {1'b1, sh[FW-1:1]};
        bits_left <= bits_left - 1'b1;
        if (bits_left == 4'd1) busy <= 1'b0;
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) txd <= 1'b1;
    else        txd <= cfg_brk ? 1'b0 : (busy ? sh[0] : 1'b1);
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R1
  AST_BREAK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_brk) |-> !txd); // R6
  AST_DIS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cfg_tx_dis) |=> !busy); // R7
  AST_CTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cfg_cts_flow && cts_n) |=> !busy); // R8
  AST_START_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(count) != '0); // R9
  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_clr && fifo_clr_en) |=> all_sent || busy); // R10

endmodule

// File: tb/uart_tx_cts_bench.sv
module uart_tx_cts_bench;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic wr_en = 0, fifo_clr = 0, fifo_clr_en = 0;
  logic [7:0] wr_data = 0;
  logic [1:0] cfg_mode = 0, irq_lvl = 0;
  logic cfg_stop2 = 0, cfg_par_en = 0, cfg_par_even = 0, cfg_brk = 0;
  logic cfg_tx_dis = 0, cfg_cts_flow = 0, cts_n = 0;
  logic txd, all_sent, tx_irq, fifo_full;

  int checks = 0, fails = 0, frames = 0, cyc = 0;
  bit mon_on = 1, mon_act = 0;
  int tc, bidx;
  logic [15:0] cur;
  logic [11:0] rxv;
  logic [15:0] expq[$];

  uart_tx_cts u_uart_tx_cts (.*);

  always #4 clk = ~clk;
  always @(posedge clk) tick <= ~tick;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] expf(input logic [7:0] d, input logic [1:0] m,
                                       input logic pe, input logic ev, input logic s2);
    logic [11:0] f;
    int n;
    logic p;
    f = '1; f[0] = 1'b0; n = 1; p = ~ev;
    for (int i = 0; i < 8; i++) begin
      if (!(m == 2'b01 && i == 7)) begin
        f[n] = d[i]; p = p ^ d[i]; n++;
      end
    end
    if (pe) begin f[n] = p; n++; end
    n += s2 ? 2 : 1;
    return {4'(n), f};
  endfunction

  always @(negedge clk) begin
    if (rst_n && mon_on) begin
      if (!mon_act) begin
        if (txd == 1'b0) begin
          if (expq.size() == 0) begin
            chk(0, "R2", "unexpected frame start", 1, 0);
            cur = {4'd10, 12'h000};
          end else cur = expq.pop_front();
          mon_act = 1; tc = 0; bidx = 0; rxv = '1;
        end
      end else if (tick) begin
        tc++;
        if (tc == 8 + 16 * bidx) begin
          rxv[bidx] = txd;
          bidx++;
          if (bidx == int'(cur[15:12])) begin
            chk(rxv == cur[11:0], "R2 R3 R4 R5", "frame bits", int'(rxv), int'(cur[11:0]));
            chk(all_sent == 1'b0, "R9", "all_sent during last stop bit", all_sent, 0);
            frames++;
            mon_act = 0;
          end
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic wr(input logic [7:0] d, input bit sent);
    @(negedge clk);
    wr_en = 1; wr_data = d;
    if (sent) expq.push_back(expf(d, cfg_mode, cfg_par_en, cfg_par_even, cfg_stop2));
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wait_idle();
    int n = 0;
    do begin @(negedge clk); n++; end while (!(all_sent && !mon_act) && n < 20000);
    repeat (40) @(negedge clk);
  endtask

  task automatic wait_frames(input int target);
    int n = 0;
    while (frames < target && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic irq_levels(input int occ);
    irq_lvl = 2'b00; #1; chk(tx_irq == (occ == 0), "R11", "irq level 00", tx_irq, occ == 0);
    irq_lvl = 2'b01; #1; chk(tx_irq == (occ <= 4), "R11", "irq level 01", tx_irq, occ <= 4);
    irq_lvl = 2'b10; #1; chk(tx_irq == (occ <= 7), "R11", "irq level 10", tx_irq, occ <= 7);
    irq_lvl = 2'b00;
  endtask

  initial begin
    int f0, gap;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(txd == 1'b1, "R2", "txd after reset", txd, 1);
    chk(all_sent == 1'b1, "R9", "all_sent after reset", all_sent, 1);
    chk(tx_irq == 1'b1, "R11", "tx_irq after reset", tx_irq, 1);
    chk(fifo_full == 1'b0, "R1", "fifo_full after reset", fifo_full, 0);

    // random frames across formats: R2 R3 R4 R5
    for (int k = 0; k < 8; k++) begin
      cfg_mode = 2'($urandom_range(0, 2));
      cfg_stop2 = 1'($urandom); cfg_par_en = 1'($urandom); cfg_par_even = 1'($urandom);
      if (k == 0) begin cfg_mode = 2'b01; cfg_par_en = 1; cfg_par_even = 0; end
      if (k == 1) begin cfg_mode = 2'b00; cfg_par_en = 1; cfg_par_even = 1; cfg_stop2 = 1; end
      for (int j = 0; j < 5; j++) begin
        while (fifo_full) @(negedge clk);
        wr(8'($urandom), 1);
        gap = $urandom_range(0, 60);
        repeat (gap) @(negedge clk);
      end
      wait_idle();
    end
    chk(frames == 40, "R2", "random frame count", frames, 40);
    cfg_mode = 0; cfg_stop2 = 0; cfg_par_en = 0;

    // fill levels, full, dropped write: R1 R11
    cfg_tx_dis = 1;
    for (int k = 0; k <= 8; k++) begin
      @(negedge clk);
      irq_levels(k);
      if (k < 8) wr(8'(8'h30 + k), 1);
    end
    chk(fifo_full == 1'b1, "R1", "fifo_full at 8", fifo_full, 1);
    wr(8'hEE, 0);
    chk(fifo_full == 1'b1, "R1", "fifo_full after dropped write", fifo_full, 1);
    f0 = frames;
    cfg_tx_dis = 0;
    wait_idle();
    chk(frames == f0 + 8, "R1", "frames after full queue", frames, f0 + 8);

    // clear qualified by enable: R10
    cfg_tx_dis = 1;
    for (int k = 0; k < 5; k++) wr(8'(8'h50 + k), 0);
    irq_lvl = 2'b01; #1;
    chk(tx_irq == 1'b0, "R10", "irq with 5 held", tx_irq, 0);
    @(negedge clk); fifo_clr = 1;
    @(negedge clk); fifo_clr = 0; #1;
    chk(tx_irq == 1'b0, "R10", "clear without enable ignored", tx_irq, 0);
    chk(all_sent == 1'b0, "R10", "all_sent after unqualified clear", all_sent, 0);
    @(negedge clk); fifo_clr = 1; fifo_clr_en = 1; wr_en = 1; wr_data = 8'hA5;
    @(negedge clk); fifo_clr = 0; fifo_clr_en = 0; wr_en = 0; #1;
    chk(all_sent == 1'b1, "R10", "qualified clear empties, write dropped", all_sent, 1);
    irq_lvl = 2'b00; #1;
    chk(tx_irq == 1'b1, "R10", "irq empty after clear", tx_irq, 1);
    f0 = frames;
    cfg_tx_dis = 0;
    repeat (600) @(negedge clk);
    chk(frames == f0, "R10", "no frames after clear", frames, f0);

    // clear-to-send gating: R8
    cfg_cts_flow = 1; cts_n = 1;
    f0 = frames;
    wr(8'h3C, 1);
    repeat (1500) @(negedge clk);
    chk(frames == f0 && txd == 1'b1, "R8", "held by cts_n high", frames, f0);
    chk(all_sent == 1'b0, "R8", "all_sent while held", all_sent, 0);
    wr(8'hC3, 1);
    cts_n = 0;
    while (!mon_act) @(negedge clk);
    repeat (40) @(negedge clk);
    cts_n = 1;
    wait_frames(f0 + 1);
    repeat (800) @(negedge clk);
    chk(frames == f0 + 1, "R8", "started frame completes, next held", frames, f0 + 1);
    chk(all_sent == 1'b0, "R8", "second byte still held", all_sent, 0);
    cts_n = 0;
    wait_idle();
    chk(frames == f0 + 2, "R8", "release sends held byte", frames, f0 + 2);
    cfg_cts_flow = 0; cts_n = 1;
    wr(8'h81, 1);
    wait_idle();
    chk(frames == f0 + 3, "R8", "cts_n ignored when flow off", frames, f0 + 3);
    cts_n = 0;

    // transmit disable mid-frame: R7
    f0 = frames;
    wr(8'h11, 1); wr(8'h22, 1);
    while (!mon_act) @(negedge clk);
    cfg_tx_dis = 1;
    wait_frames(f0 + 1);
    repeat (800) @(negedge clk);
    chk(frames == f0 + 1, "R7", "disable holds next frame", frames, f0 + 1);
    chk(all_sent == 1'b0, "R7", "byte still held", all_sent, 0);
    cfg_tx_dis = 0;
    wait_idle();
    chk(frames == f0 + 2, "R7", "resume after disable", frames, f0 + 2);

    // write coinciding with frame-start pop: R12
    f0 = frames;
    cfg_tx_dis = 1;
    wr(8'h6A, 1);
    do @(negedge clk); while (tick != 1'b1);
    cfg_tx_dis = 0; wr_en = 1; wr_data = 8'h95;
    expq.push_back(expf(8'h95, cfg_mode, cfg_par_en, cfg_par_even, cfg_stop2));
    @(negedge clk);
    wr_en = 0; cfg_tx_dis = 1;
    irq_levels(1);
    wait_frames(f0 + 1);
    repeat (800) @(negedge clk);
    chk(frames == f0 + 1 && all_sent == 1'b0, "R12", "one byte remains after overlap", frames, f0 + 1);
    cfg_tx_dis = 0;
    wait_idle();
    chk(frames == f0 + 2, "R12", "both overlapped bytes sent", frames, f0 + 2);

    // break: R6
    mon_on = 0;
    @(negedge clk); cfg_brk = 1;
    @(negedge clk);
    chk(txd == 1'b0, "R6", "txd low after break set", txd, 0);
    repeat (200) @(negedge clk);
    chk(txd == 1'b0, "R6", "txd held low during break", txd, 0);
    cfg_brk = 0;
    @(negedge clk);
    chk(txd == 1'b1, "R6", "txd released after break", txd, 1);
    mon_on = 1;
    chk(expq.size() == 0, "R2", "expected queue drained", expq.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule